// File: doc/BRIEF.md
# Segment Descriptor Lookup and Local Table Load Unit

This unit turns a 16-bit segment selector into a descriptor address, fetches the 8-byte descriptor from memory and decodes it. The selector's table-indicator bit chooses between the global table and the current local table. The unit also executes the instruction that loads the local-table register. In that case it runs extra checks on the fetched descriptor and either updates the local-table base, limit and selector or reports a fault.

A request is presented for one cycle on `op_valid`. `op_ldt_load` chooses a plain lookup (0) or a local-table load (1). The unit reads memory through a request/acknowledge port, one 32-bit word per transfer: low word first, then high word. It finishes with a one-cycle `done` pulse that carries a 2-bit result and a fault code. The global-table base and limit are written through a dedicated load port. The current local-table selector, base and limit are always visible on output ports.

Top module: `desc_lookup_unit`

## Requirements
- R1: A descriptor's byte offset is the selector with bits 2:0 forced to zero. The descriptor is read as two 32-bit transfers: the first at table base + offset, the second at table base + offset + 4. Each transfer holds `mem_req` and `mem_addr` steady until `mem_ack`.
- R2: Selector bit 2 set selects the local table's base and limit. Bit 2 clear selects the global table's base and limit.
- R3: If the offset is greater than or equal to the chosen table's limit, no memory transfer is issued. The request ends with result 2'b01 (protection fault) and `fault_code` equal to the selector.
- R4: On a successful lookup the unit presents the descriptor fields on the `seg_*` ports. Base is {bits 63:56, 39:32, 31:16}. Type is bits 44:40, privilege level is bits 46:45 and present is bit 47. The result is 2'b00.
- R5: The raw limit is {bits 51:48, 15:0}. When bit 55 (granularity) is set, the reported limit is the raw limit shifted left by 12 with ones in bits 11:0. Otherwise the reported limit is the raw limit zero-extended.
- R6: A local-table load whose selector has bits 15:2 all zero reads no memory. It sets the local selector, base and limit to zero and ends with result 2'b00.
- R7: A local-table load that fails the limit check, or whose descriptor type is not 5'h02, ends with result 2'b01 and `fault_code` equal to the selector.
- R8: A local-table load whose descriptor has type 5'h02 and present bit clear ends with result 2'b10 (not-present fault) and `fault_code` equal to the selector.
- R9: A successful local-table load sets `ldt_base` and `ldt_limit` from the descriptor (limit as in R5) and sets `ldt_sel` to the full selector. A faulting request leaves all three unchanged.
- R10: A global-table write on the load port is used by a request presented in the next cycle. Reset sets the local selector, base and limit to zero.
- R11: `busy` is high from the cycle after a request that reads memory is accepted until the end of that request. `done` is high for exactly one cycle. `op_valid` is ignored while `busy` or `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gdt_wr_en | input | 1 | Write global-table base and limit |
| gdt_wr_base | input | 32 | New global-table base |
| gdt_wr_limit | input | 32 | New global-table limit |
| op_valid | input | 1 | Request strobe |
| op_ldt_load | input | 1 | 0 = plain lookup, 1 = local-table load |
| op_sel | input | 16 | Selector of the request |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request completed (one cycle) |
| result | output | 2 | 00 success, 01 protection fault, 10 not-present fault |
| fault_code | output | 16 | Selector of the completed request |
| seg_base | output | 32 | Decoded descriptor base |
| seg_limit | output | 32 | Decoded effective limit |
| seg_type | output | 5 | Decoded type field |
| seg_dpl | output | 2 | Decoded privilege level |
| seg_present | output | 1 | Decoded present bit |
| ldt_sel | output | 16 | Current local-table selector |
| ldt_base | output | 32 | Current local-table base |
| ldt_limit | output | 32 | Current local-table limit |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Memory read acknowledge, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The hardest cases to reach are those where the local-table register feeds back into the next lookup. A table-indicator selector resolves against whatever the last successful load installed, and after a null load such a selector must fail at limit zero. The stimulus places directed entries in the global table (a valid local-table descriptor, a non-present one and a data segment) and chains loads and lookups through them. It then runs random selectors that mix both tables, all privilege bits, and indices up to and past the table limit, including an offset exactly equal to it. A separate directed case strobes a second request while the memory reads of the first are still outstanding.

// File: rtl/desc_pkg.sv
package desc_pkg;
    // Widths fixed by the 8-byte descriptor format and the 16-bit selector.
    localparam int LIN_W  = 32;
    localparam int SEL_W  = 16;
    localparam int WORD_W = 32;
    localparam int DESC_W = 2 * WORD_W;
    localparam int IDX_LO = 3;
    localparam logic [4:0] TYPE_LOCAL_TABLE = 5'h02;

    typedef enum logic [1:0] {ST_IDLE, ST_RD_LO, ST_RD_HI} fsm_e;
    typedef enum logic [1:0] {RES_OK = 2'b00, RES_GP = 2'b01, RES_NP = 2'b10} res_e;
    typedef enum logic {OP_LOOKUP = 1'b0, OP_LDT_LOAD = 1'b1} op_e;

    typedef struct packed {
        logic [LIN_W-1:0] base;
        logic [LIN_W-1:0] limit;
    } tbl_t;

    typedef struct packed {
        logic [LIN_W-1:0] base;
        logic [LIN_W-1:0] limit;
        logic [4:0]       kind;
        logic [1:0]       dpl;
        logic             present;
    } desc_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [LIN_W-1:0] base;
        logic [LIN_W-1:0] limit;
    } ldt_t;

    typedef struct packed {
        fsm_e              st;
        op_e               op;
        logic [SEL_W-1:0]  sel;
        logic [LIN_W-1:0]  addr;
        logic [WORD_W-1:0] lo;
        logic              done;
        res_e              res;
        logic [SEL_W-1:0]  err;
        desc_t             desc;
        ldt_t              ldt;
    } core_t;
endpackage

// File: rtl/desc_gdt_regs.sv
module desc_gdt_regs
    import desc_pkg::*;
#(
    parameter logic [LIN_W-1:0] RST_BASE  = '0,
    parameter logic [LIN_W-1:0] RST_LIMIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LIN_W-1:0] wr_base,
    input  logic [LIN_W-1:0] wr_limit,
    output tbl_t             gdt
);
    tbl_t gdt_d, gdt_q;

    always_comb begin
        gdt_d = gdt_q;
        if (wr_en) begin
            gdt_d.base  = wr_base;
            gdt_d.limit = wr_limit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gdt_q.base  <= RST_BASE;
            gdt_q.limit <= RST_LIMIT;
        end else begin
            gdt_q <= gdt_d;
        end
    end

    assign gdt = gdt_q;
endmodule

// File: rtl/desc_table_sel.sv
module desc_table_sel
    import desc_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  tbl_t             gdt,
    input  tbl_t             ldt,
    output logic [LIN_W-1:0] first_addr,
    output logic             in_range,
    output logic             null_sel
);
    localparam int PAD_W = LIN_W - SEL_W;

    logic [LIN_W-1:0] offset;
    tbl_t             chosen;

    always_comb begin
        offset     = {{PAD_W{1'b0}}, sel[SEL_W-1:IDX_LO], {IDX_LO{1'b0}}};
        chosen     = sel[2] ? ldt : gdt;
        in_range   = offset < chosen.limit;
        first_addr = chosen.base + offset;
        null_sel   = (sel[SEL_W-1:2] == '0);
    end
endmodule

// File: rtl/desc_field_decode.sv
module desc_field_decode
    import desc_pkg::*;
(
    input  logic [DESC_W-1:0] raw,
    output desc_t             fields
);
    localparam int RAW_LIM_W = 20;
    localparam int PAGE_SH   = 12;

    logic [RAW_LIM_W-1:0] raw_limit;
    logic                 gran;

    always_comb begin
        raw_limit      = {raw[51:48], raw[15:0]};
        gran           = raw[55];
        fields.base    = {raw[63:56], raw[39:32], raw[31:16]};
        fields.kind    = raw[44:40];
        fields.dpl     = raw[46:45];
        fields.present = raw[47];
        if (gran) begin
            fields.limit = {raw_limit, {PAGE_SH{1'b1}}};
        end else begin
            fields.limit = {{(LIN_W-RAW_LIM_W){1'b0}}, raw_limit};
        end
    end
endmodule

// File: rtl/desc_lookup_unit.sv
module desc_lookup_unit
    import desc_pkg::*;
#(
    parameter logic [31:0] GDT_RST_BASE  = 32'h0,
    parameter logic [31:0] GDT_RST_LIMIT = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        gdt_wr_en,
    input  logic [31:0] gdt_wr_base,
    input  logic [31:0] gdt_wr_limit,
    input  logic        op_valid,
    input  logic        op_ldt_load,
    input  logic [15:0] op_sel,
    output logic        busy,
    output logic        done,
    output logic [1:0]  result,
    output logic [15:0] fault_code,
    output logic [31:0] seg_base,
    output logic [31:0] seg_limit,
    output logic [4:0]  seg_type,
    output logic [1:0]  seg_dpl,
    output logic        seg_present,
    output logic [15:0] ldt_sel,
    output logic [31:0] ldt_base,
    output logic [31:0] ldt_limit,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam logic [LIN_W-1:0] WORD_BYTES = LIN_W'(WORD_W / 8);

    core_t            core_d, core_q;
    tbl_t             gdt_cur;
    tbl_t             ldt_cur;
    logic [LIN_W-1:0] first_addr;
    logic             in_range;
    logic             null_sel;
    desc_t            dec;
    logic             accept;

    desc_gdt_regs #(
        .RST_BASE  (GDT_RST_BASE),
        .RST_LIMIT (GDT_RST_LIMIT)
    ) u_gdt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (gdt_wr_en),
        .wr_base  (gdt_wr_base),
        .wr_limit (gdt_wr_limit),
        .gdt      (gdt_cur)
    );

    assign ldt_cur.base  = core_q.ldt.base;
    assign ldt_cur.limit = core_q.ldt.limit;

    desc_table_sel u_sel (
        .sel        (op_sel),
        .gdt        (gdt_cur),
        .ldt        (ldt_cur),
        .first_addr (first_addr),
        .in_range   (in_range),
        .null_sel   (null_sel)
    );

    // High word is taken straight from the read bus on its acknowledge.
    desc_field_decode u_dec (
        .raw    ({mem_rdata, core_q.lo}),
        .fields (dec)
    );

    assign accept = (core_q.st == ST_IDLE) && !core_q.done && op_valid;

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        unique case (core_q.st)
            ST_IDLE: begin
                if (accept) begin
                    core_d.op  = op_ldt_load ? OP_LDT_LOAD : OP_LOOKUP;
                    core_d.sel = op_sel;
                    core_d.err = op_sel;
                    if (op_ldt_load && null_sel) begin
                        core_d.ldt  = '0;
                        core_d.res  = RES_OK;
                        core_d.done = 1'b1;
                    end else if (!in_range) begin
                        core_d.res  = RES_GP;
                        core_d.done = 1'b1;
                    end else begin
                        core_d.addr = first_addr;
                        core_d.st   = ST_RD_LO;
                    end
                end
            end
            ST_RD_LO: begin
                if (mem_ack) begin
                    core_d.lo   = mem_rdata;
                    core_d.addr = core_q.addr + WORD_BYTES;
                    core_d.st   = ST_RD_HI;
                end
            end
            ST_RD_HI: begin
                if (mem_ack) begin
                    core_d.st   = ST_IDLE;
                    core_d.done = 1'b1;
                    core_d.desc = dec;
                    core_d.res  = RES_OK;
                    if (core_q.op == OP_LDT_LOAD) begin
                        if (dec.kind != TYPE_LOCAL_TABLE) begin
                            core_d.res = RES_GP;
                        end else if (!dec.present) begin
                            core_d.res = RES_NP;
                        end else begin
                            core_d.ldt.sel   = core_q.sel;
                            core_d.ldt.base  = dec.base;
                            core_d.ldt.limit = dec.limit;
                        end
                    end
                end
            end
            default: core_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q    <= '0;
            core_q.st <= ST_IDLE;
        end else begin
            core_q <= core_d;
        end
    end

    assign busy        = (core_q.st != ST_IDLE);
    assign done        = core_q.done;
    assign result      = core_q.res;
    assign fault_code  = core_q.err;
    assign seg_base    = core_q.desc.base;
    assign seg_limit   = core_q.desc.limit;
    assign seg_type    = core_q.desc.kind;
    assign seg_dpl     = core_q.desc.dpl;
    assign seg_present = core_q.desc.present;
    assign ldt_sel     = core_q.ldt.sel;
    assign ldt_base    = core_q.ldt.base;
    assign ldt_limit   = core_q.ldt.limit;
    assign mem_req     = (core_q.st == ST_RD_LO) || (core_q.st == ST_RD_HI);
    assign mem_addr    = core_q.addr;

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_req_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_second_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_RD_LO && mem_ack) |=> (mem_req && mem_addr == $past(mem_addr) + WORD_BYTES));

    assert_fault_keeps_ldt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != RES_OK) |-> ($stable(ldt_sel) && $stable(ldt_base) && $stable(ldt_limit)));

    assert_legal_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'b11));
endmodule

// File: tb/tb_desc_lookup_unit.sv
module tb_desc_lookup_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        gdt_wr_en;
    logic [31:0] gdt_wr_base, gdt_wr_limit;
    logic        op_valid, op_ldt_load;
    logic [15:0] op_sel;
    logic        busy, done, seg_present, mem_req, mem_ack;
    logic [1:0]  result, seg_dpl;
    logic [15:0] fault_code, ldt_sel;
    logic [31:0] seg_base, seg_limit, ldt_base, ldt_limit, mem_addr, mem_rdata;
    logic [4:0]  seg_type;

    always #2 clk = ~clk;

    desc_lookup_unit dut (
        .clk(clk), .rst_n(rst_n), .gdt_wr_en(gdt_wr_en), .gdt_wr_base(gdt_wr_base),
        .gdt_wr_limit(gdt_wr_limit), .op_valid(op_valid), .op_ldt_load(op_ldt_load),
        .op_sel(op_sel), .busy(busy), .done(done), .result(result), .fault_code(fault_code),
        .seg_base(seg_base), .seg_limit(seg_limit), .seg_type(seg_type), .seg_dpl(seg_dpl),
        .seg_present(seg_present), .ldt_sel(ldt_sel), .ldt_base(ldt_base), .ldt_limit(ldt_limit),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    logic [31:0] mem [0:1023];
    int          ack_cnt;
    logic [31:0] ack_addr [0:1];
    int          wait_cnt;
    // bench model of table registers
    logic [31:0] m_gdt_base, m_gdt_limit, m_ldt_base, m_ldt_limit;
    logic [15:0] m_ldt_sel;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        if (a < 32'd4096) return mem[a[11:2]];
        return 32'h0;
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic [63:0] d);
        mem[a[11:2]]      = d[31:0];
        mem[a[11:2] + 1]  = d[63:32];
    endtask

    function automatic logic [63:0] gen_desc();
        logic [31:0] lo, hi;
        lo = $urandom;
        hi = $urandom;
        if ($urandom_range(0, 1) == 1) begin
            lo[31:16] = 16'h0600;
            hi[7:0]   = 8'h00;
            hi[31:24] = 8'h00;
            hi[12:8]  = 5'h02;
            lo[15:0]  = 16'($urandom_range(0, 159));
            hi[19:16] = 4'h0;
        end
        return {hi, lo};
    endfunction

    function automatic logic [31:0] ref_limit(input logic [63:0] d);
        logic [19:0] r;
        r = {d[51:48], d[15:0]};
        return d[55] ? {r, 12'hfff} : {12'h000, r};
    endfunction

    // memory responder: one-cycle ack after 0..2 idle cycles
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                mem_ack   = 1'b1;
                mem_rdata = rd_word(mem_addr);
                if (ack_cnt < 2) ack_addr[ack_cnt] = mem_addr;
                ack_cnt++;
                wait_cnt = $urandom_range(0, 2);
            end else begin
                wait_cnt--;
            end
        end
    end

    task automatic load_gdt(input logic [31:0] b, input logic [31:0] l);
        @(negedge clk);
        gdt_wr_en = 1'b1; gdt_wr_base = b; gdt_wr_limit = l;
        @(negedge clk);
        gdt_wr_en = 1'b0;
        m_gdt_base = b; m_gdt_limit = l;
    endtask

    task automatic run_op(input logic ld, input logic [15:0] sel);
        logic [31:0] off, tb, tl, eres;
        logic [63:0] d;
        int          eacks, n;
        logic        got_busy;
        string       rtag;
        off = {16'h0, sel[15:3], 3'b000};
        tb  = sel[2] ? m_ldt_base : m_gdt_base;
        tl  = sel[2] ? m_ldt_limit : m_gdt_limit;
        d   = {rd_word(tb + off + 32'd4), rd_word(tb + off)};
        rtag = ld ? "R7" : "R3";
        if (ld && sel[15:2] == 14'h0) begin
            eres = 0; eacks = 0; rtag = "R6";
        end else if (off >= tl) begin
            eres = 1; eacks = 0;
        end else begin
            eacks = 2;
            if (!ld) begin eres = 0; rtag = "R4"; end
            else if (d[44:40] != 5'h02) eres = 1;
            else if (!d[47]) begin eres = 2; rtag = "R8"; end
            else begin eres = 0; rtag = "R9"; end
        end
        @(negedge clk);
        ack_cnt = 0;
        op_valid = 1'b1; op_ldt_load = ld; op_sel = sel;
        @(negedge clk);
        op_valid = 1'b0;
        got_busy = busy;
        n = 0;
        while (!done && n < 60) begin @(negedge clk); n++; end
        chk("R11 done seen", {31'h0, done}, 32'h1);
        chk("R11 busy while reading", {31'h0, got_busy}, {31'h0, eacks != 0});
        chk({rtag, " result"}, {30'h0, result}, eres);
        if (eres != 0) chk({rtag, " fault code"}, {16'h0, fault_code}, {16'h0, sel});
        chk("R3 read count", ack_cnt, eacks);
        if (eacks == 2) begin
            chk(sel[2] ? "R2 first addr local" : "R1 first addr", ack_addr[0], tb + off);
            chk("R1 second addr", ack_addr[1], tb + off + 32'd4);
        end
        if (eacks == 2 && !ld) begin
            chk("R4 base", seg_base, {d[63:56], d[39:32], d[31:16]});
            chk("R5 limit", seg_limit, ref_limit(d));
            chk("R4 type/dpl/p", {24'h0, seg_type, seg_dpl, seg_present}, {24'h0, d[44:40], d[46:45], d[47]});
        end
        if (ld && eres == 0) begin
            if (eacks == 0) begin
                m_ldt_sel = 16'h0; m_ldt_base = 32'h0; m_ldt_limit = 32'h0;
            end else begin
                m_ldt_sel = sel; m_ldt_base = {d[63:56], d[39:32], d[31:16]}; m_ldt_limit = ref_limit(d);
            end
        end
        @(negedge clk);
        chk("R11 done one cycle", {31'h0, done}, 32'h0);
        chk("R9 ldt sel", {16'h0, ldt_sel}, {16'h0, m_ldt_sel});
        chk("R9 ldt base", ldt_base, m_ldt_base);
        chk("R9 ldt limit", ldt_limit, m_ldt_limit);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int seed_dummy, dones;
        seed_dummy = $urandom(32'h00C0FFEE);
        rst_n = 1'b0; gdt_wr_en = 1'b0; gdt_wr_base = 0; gdt_wr_limit = 0;
        op_valid = 1'b0; op_ldt_load = 1'b0; op_sel = 0; mem_rdata = 0; ack_cnt = 0;
        m_ldt_sel = 0; m_ldt_base = 0; m_ldt_limit = 0; m_gdt_base = 0; m_gdt_limit = 0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        for (int i = 0; i < 16; i++) put_desc(32'h200 + 32'(i * 8), gen_desc());
        for (int i = 0; i < 24; i++) put_desc(32'h600 + 32'(i * 8), gen_desc());
        // directed entries: 1 valid local table, 2 local table not present, 3 data segment paged
        put_desc(32'h208, 64'h0000_8200_0600_00BF);
        put_desc(32'h210, 64'h0000_6200_0600_0040);
        put_desc(32'h218, 64'h1283_F212_3456_0002);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset ldt sel", {16'h0, ldt_sel}, 32'h0);
        chk("R10 reset ldt base", ldt_base, 32'h0);
        chk("R10 reset ldt limit", ldt_limit, 32'h0);
        chk("R11 reset idle", {30'h0, busy, done}, 32'h0);

        load_gdt(32'h200, 32'h80);
        run_op(1'b0, 16'h0018);           // R4 R5 paged data segment
        run_op(1'b1, 16'h000B);           // R9 success with RPL bits
        run_op(1'b0, 16'h000C);           // R2 lookup in local table
        run_op(1'b1, 16'h0010);           // R8 not present
        run_op(1'b1, 16'h0018);           // R7 wrong type
        run_op(1'b1, 16'h0080);           // R3 R7 offset equal to limit
        run_op(1'b0, 16'h0078);           // R3 last entry in range
        run_op(1'b1, 16'h0004);           // R6 not null: resolves in local table
        run_op(1'b1, 16'h0003);           // R6 null load clears
        run_op(1'b0, 16'h0004);           // R2 R3 local limit now zero

        // R10: new global limit used by the very next request
        @(negedge clk);
        gdt_wr_en = 1'b1; gdt_wr_base = 32'h200; gdt_wr_limit = 32'h10;
        m_gdt_limit = 32'h10;
        run_op(1'b0, 16'h0018);
        gdt_wr_en = 1'b0;
        load_gdt(32'h200, 32'h80);

        // R11: second strobe during a busy request is ignored
        @(negedge clk);
        ack_cnt = 0;
        op_valid = 1'b1; op_ldt_load = 1'b0; op_sel = 16'h0018;
        @(negedge clk);
        op_sel = 16'h0008; op_ldt_load = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        dones = 0;
        for (int k = 0; k < 20; k++) begin
            if (done) dones++;
            @(negedge clk);
        end
        chk("R11 ignored strobe: one completion", dones, 1);
        chk("R11 ignored strobe: two reads", ack_cnt, 2);
        chk("R11 ignored strobe: first request type", {27'h0, seg_type}, 32'h12);
        chk("R11 ignored strobe: ldt unchanged", {16'h0, ldt_sel}, {16'h0, m_ldt_sel});

        for (int i = 0; i < 400; i++) begin
            logic [15:0] s;
            s = {13'($urandom_range(0, 19)), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3))};
            if ($urandom_range(0, 15) == 0) s[15:2] = 14'h0;
            run_op(1'($urandom_range(0, 1)), s);
        end
        report();
    end
endmodule